// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the drive waveforms for a passive LCD panel scanned at one-quarter duty with half bias. The panel has four common electrodes and eighteen segment electrodes, so up to seventy-two pixels can be lit. Every pin carries a two-bit level code. An analog stage outside the block turns each code into ground, half of the supply, or the full supply.

A one-cycle timebase tick drives the scan. After a set number of ticks the block moves to the next common slot. At the start of each slot it takes one row of the 72-bit segment image. The drive polarity flips at the end of every frame (four slots), so no pixel sees any net DC voltage over two frames.

Both after reset and after a resume request (used when leaving a clock-stop state), every pin is held at the mid level for one full step before the first common is scanned. When the enable input is low, all pins are pulled to the low level. Scanning continues in the background while the display is disabled.

Top module: `lcd_mux_drv`

## Requirements
- R1: After reset, every common and segment output shows the mid code 2'b01, whatever the enable input is. This lasts until TICKS_PER_STEP ticks have arrived. On that tick's edge, scanning starts in slot 0 with even polarity.
- R2: A resume pulse puts every pin at the mid code from the next cycle on. It also clears the tick count and restarts the scan from slot 0 with even polarity after one more full step. A tick in the same cycle as resume is discarded.
- R3: Every output uses only the codes low = 2'b00, mid = 2'b01 and high = 2'b10. The code 2'b11 never appears.
- R4: One step takes exactly TICKS_PER_STEP ticks. Each step advances the active common by one, in the order 0, 1, 2, 3, then back to 0. Ticks short of a full step change no output.
- R5: While scanning and enabled, the active common shows high in even frames and low in odd frames. Every other common shows mid. Common c occupies com_lvl[2c+1:2c].
- R6: While scanning and enabled, a segment whose pixel is on shows the full level opposite the active common. A segment whose pixel is off shows the same level as the active common. The pixel under common c and segment s is seg_img[c*N_SEG+s], and segment s occupies seg_lvl[2s+1:2s].
- R7: Polarity starts even. It toggles only when the scan wraps from the last common back to common 0.
- R8: With a fixed image, summing (common level − segment level) over any eight consecutive steps gives zero for every pixel. For this sum, low=0, mid=1, high=2.
- R9: While scanning, a low enable drives every pin to the low code. Slot and polarity keep advancing, so after re-enable the pattern matches an uninterrupted scan.
- R10: The image is sampled only on the edge that starts a slot. Image changes during a slot do not reach the segment outputs before the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_en | input | 1 | Display enable; low forces all pins low while scanning |
| resume | input | 1 | One-cycle pulse that restarts the mid-level start-up phase |
| step_tick | input | 1 | One-cycle timebase tick |
| seg_img | input | 72 | Segment image; bit c*18+s is the pixel at common c, segment s |
| com_lvl | output | 8 | Level codes of the four commons, two bits each |
| seg_lvl | output | 36 | Level codes of the eighteen segments, two bits each |

## Verification
Three events can coincide with a step edge. The first is an image change. The bench writes a new image in the half cycle before the tick that completes a step, so the new row must appear at once. The same image written one tick earlier must not appear. The second is a disable spanning several steps: the bench lowers enable, keeps ticking, and checks that all pins are low. After re-enable it checks that the slot and polarity match a model that never paused. The third is a resume pulse in the same cycle as a tick: the tick must be lost, and start-up must last a full step counted from the resume.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

   localparam logic [1:0] LV_LOW  = 2'b00;
   localparam logic [1:0] LV_MID  = 2'b01;
   localparam logic [1:0] LV_HIGH = 2'b10;

   // full-swing level: neg=1 gives ground, neg=0 gives supply
   function automatic logic [1:0] full_lvl(input logic neg);
      return neg ? LV_LOW : LV_HIGH;
   endfunction

endpackage

// File: rtl/lcd_step_timer.sv
module lcd_step_timer #(
   parameter int TICKS_PER_STEP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   output logic step_o
);

   localparam int DIV_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS_PER_STEP - 1);

   generate
      if (TICKS_PER_STEP == 1) begin : g_direct
         assign step_o = tick_i & ~clr_i;
      end else begin : g_count
         logic [DIV_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr_i) begin
               cnt_q <= '0;
            end else if (tick_i) begin
               if (cnt_q == DIV_LAST) cnt_q <= '0;
               else                   cnt_q <= cnt_q + 1'b1;
            end
         end

         assign step_o = tick_i & ~clr_i & (cnt_q == DIV_LAST);
      end
   endgenerate

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
   parameter int N_COM = 4,
   parameter int N_SEG = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart_i,
   input  logic                     step_i,
   input  logic [N_COM*N_SEG-1:0]   img_i,
   output logic                     startup_o,
   output logic [$clog2(N_COM)-1:0] slot_o,
   output logic                     pol_o,
   output logic [N_SEG-1:0]         row_o
);

   localparam int SLOT_W = $clog2(N_COM);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_COM - 1);

   logic [N_SEG-1:0]  img_rows [N_COM];
   logic              startup_q;
   logic              pol_q;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] slot_nxt;
   logic [N_SEG-1:0]  row_q;
   logic              wrap;

   genvar gc;
   generate
      for (gc = 0; gc < N_COM; gc++) begin : g_rows
         assign img_rows[gc] = img_i[gc*N_SEG +: N_SEG];
      end
   endgenerate

   assign wrap     = (slot_q == SLOT_LAST);
   assign slot_nxt = (startup_q || wrap) ? '0 : slot_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         startup_q <= 1'b1;
         slot_q    <= '0;
         pol_q     <= 1'b0;
         row_q     <= '0;
      end else if (restart_i) begin
         startup_q <= 1'b1;
         slot_q    <= '0;
         pol_q     <= 1'b0;
      end else if (step_i) begin
         startup_q <= 1'b0;
         slot_q    <= slot_nxt;
         row_q     <= img_rows[slot_nxt];
         if (startup_q)  pol_q <= 1'b0;
         else if (wrap)  pol_q <= ~pol_q;
      end
   end

   assign startup_o = startup_q;
   assign slot_o    = slot_q;
   assign pol_o     = pol_q;
   assign row_o     = row_q;

endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
   import lcd_drv_pkg::*;
#(
   parameter int N_COM = 4
) (
   input  logic                     startup_i,
   input  logic                     en_i,
   input  logic [$clog2(N_COM)-1:0] slot_i,
   input  logic                     pol_i,
   output logic [2*N_COM-1:0]       com_lvl_o
);

   localparam int SLOT_W = $clog2(N_COM);

   genvar gc;
   generate
      for (gc = 0; gc < N_COM; gc++) begin : g_com
         logic [1:0] lvl;
         always_comb begin
            if (startup_i)                   lvl = LV_MID;
            else if (!en_i)                  lvl = LV_LOW;
            else if (slot_i == SLOT_W'(gc))  lvl = full_lvl(pol_i);
            else                             lvl = LV_MID;
         end
         assign com_lvl_o[2*gc +: 2] = lvl;
      end
   endgenerate

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
   import lcd_drv_pkg::*;
#(
   parameter int N_SEG = 18
) (
   input  logic               startup_i,
   input  logic               en_i,
   input  logic               pol_i,
   input  logic [N_SEG-1:0]   row_i,
   output logic [2*N_SEG-1:0] seg_lvl_o
);

   genvar gs;
   generate
      for (gs = 0; gs < N_SEG; gs++) begin : g_seg
         logic [1:0] lvl;
         always_comb begin
            if (startup_i)   lvl = LV_MID;
            else if (!en_i)  lvl = LV_LOW;
            else             lvl = full_lvl(row_i[gs] ^ pol_i);
         end
         assign seg_lvl_o[2*gs +: 2] = lvl;
      end
   endgenerate

endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv #(
   parameter int N_COM          = 4,
   parameter int N_SEG          = 18,
   parameter int TICKS_PER_STEP = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   disp_en,
   input  logic                   resume,
   input  logic                   step_tick,
   input  logic [N_COM*N_SEG-1:0] seg_img,
   output logic [2*N_COM-1:0]     com_lvl,
   output logic [2*N_SEG-1:0]     seg_lvl
);

   localparam int SLOT_W = $clog2(N_COM);

   generate
      if (N_COM < 2 || N_COM > 8) begin : g_bad_com
         $error("lcd_mux_drv: N_COM must lie in 2..8");
      end
      if (N_SEG < 1 || N_SEG > 64) begin : g_bad_seg
         $error("lcd_mux_drv: N_SEG must lie in 1..64");
      end
      if (TICKS_PER_STEP < 1) begin : g_bad_tps
         $error("lcd_mux_drv: TICKS_PER_STEP must be at least 1");
      end
   endgenerate

   logic              step_pulse;
   logic              scan_startup;
   logic [SLOT_W-1:0] scan_slot;
   logic              scan_pol;
   logic [N_SEG-1:0]  scan_row;

   lcd_step_timer #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (resume),
      .tick_i (step_tick),
      .step_o (step_pulse)
   );

   lcd_scan_ctrl #(.N_COM(N_COM), .N_SEG(N_SEG)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (resume),
      .step_i    (step_pulse),
      .img_i     (seg_img),
      .startup_o (scan_startup),
      .slot_o    (scan_slot),
      .pol_o     (scan_pol),
      .row_o     (scan_row)
   );

   lcd_com_drv #(.N_COM(N_COM)) u_com (
      .startup_i (scan_startup),
      .en_i      (disp_en),
      .slot_i    (scan_slot),
      .pol_i     (scan_pol),
      .com_lvl_o (com_lvl)
   );

   lcd_seg_drv #(.N_SEG(N_SEG)) u_seg (
      .startup_i (scan_startup),
      .en_i      (disp_en),
      .pol_i     (scan_pol),
      .row_i     (scan_row),
      .seg_lvl_o (seg_lvl)
   );

endmodule

// File: rtl/lcd_mux_drv_chk.sv
module lcd_mux_drv_chk #(
   parameter int N_COM = 4,
   parameter int N_SEG = 18
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 disp_en,
   input logic                 resume,
   input logic                 startup,
   input logic [2*N_COM-1:0]   com_lvl,
   input logic [2*N_SEG-1:0]   seg_lvl
);

   logic any_bad, all_mid, all_low;
   int   com_mid_n, com_full_n, seg_mid_n;

   always_comb begin
      any_bad    = 1'b0;
      all_mid    = 1'b1;
      all_low    = 1'b1;
      com_mid_n  = 0;
      com_full_n = 0;
      seg_mid_n  = 0;
      for (int c = 0; c < N_COM; c++) begin
         if (com_lvl[2*c +: 2] == 2'b11) any_bad = 1'b1;
         if (com_lvl[2*c +: 2] != 2'b01) all_mid = 1'b0;
         if (com_lvl[2*c +: 2] != 2'b00) all_low = 1'b0;
         if (com_lvl[2*c +: 2] == 2'b01) com_mid_n++;
         if (com_lvl[2*c +: 2] == 2'b00 || com_lvl[2*c +: 2] == 2'b10) com_full_n++;
      end
      for (int s = 0; s < N_SEG; s++) begin
         if (seg_lvl[2*s +: 2] == 2'b11) any_bad = 1'b1;
         if (seg_lvl[2*s +: 2] != 2'b01) all_mid = 1'b0;
         if (seg_lvl[2*s +: 2] != 2'b00) all_low = 1'b0;
         if (seg_lvl[2*s +: 2] == 2'b01) seg_mid_n++;
      end
   end

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !any_bad); // R3

   AST_STARTUP_MID: assert property (@(posedge clk) disable iff (!rst_n)
      startup |-> all_mid); // R1

   AST_RESUME_MID: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> (startup && all_mid)); // R2

   AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!startup && !disp_en) |-> all_low); // R9

   AST_ONE_ACTIVE_COM: assert property (@(posedge clk) disable iff (!rst_n)
      (!startup && disp_en) |-> (com_full_n == 1 && com_mid_n == N_COM - 1)); // R5

   AST_SEG_FULL_SWING: assert property (@(posedge clk) disable iff (!rst_n)
      (!startup && disp_en) |-> (seg_mid_n == 0)); // R6

endmodule

bind lcd_mux_drv lcd_mux_drv_chk #(.N_COM(N_COM), .N_SEG(N_SEG)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .disp_en (disp_en),
   .resume  (resume),
   .startup (scan_startup),
   .com_lvl (com_lvl),
   .seg_lvl (seg_lvl)
);

// File: tb/sim_lcd_mux_drv.sv
module sim_lcd_mux_drv;

   localparam int CLK_PERIOD = 10;
   localparam int NC  = 4;
   localparam int NS  = 18;
   localparam int TPS = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               disp_en = 1'b0;
   logic               resume = 1'b0;
   logic               step_tick = 1'b0;
   logic [NC*NS-1:0]   seg_img = '0;
   logic [2*NC-1:0]    com_lvl;
   logic [2*NS-1:0]    seg_lvl;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // bench model
   bit          m_start;
   int          m_slot;
   bit          m_pol;
   int          m_cnt;
   logic [NS-1:0] m_row;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_mux_drv #(.N_COM(NC), .N_SEG(NS), .TICKS_PER_STEP(TPS)) u0 (
      .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .resume(resume),
      .step_tick(step_tick), .seg_img(seg_img),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   function automatic logic [2*NC-1:0] exp_com();
      logic [2*NC-1:0] v;
      for (int c = 0; c < NC; c++) begin
         if (m_start)          v[2*c +: 2] = 2'b01;
         else if (!disp_en)    v[2*c +: 2] = 2'b00;
         else if (c == m_slot) v[2*c +: 2] = m_pol ? 2'b00 : 2'b10;
         else                  v[2*c +: 2] = 2'b01;
      end
      return v;
   endfunction

   function automatic logic [2*NS-1:0] exp_seg();
      logic [2*NS-1:0] v;
      for (int s = 0; s < NS; s++) begin
         if (m_start)                 v[2*s +: 2] = 2'b01;
         else if (!disp_en)           v[2*s +: 2] = 2'b00;
         else if (m_row[s] == m_pol)  v[2*s +: 2] = 2'b10;
         else                         v[2*s +: 2] = 2'b00;
      end
      return v;
   endfunction

   function automatic int lv(input logic [1:0] code);
      return (code == 2'b10) ? 2 : (code == 2'b01) ? 1 : 0;
   endfunction

   task automatic check_pins(input string tag);
      logic [2*NC-1:0] ec;
      logic [2*NS-1:0] es;
      ec = exp_com();
      es = exp_seg();
      n_chk++;
      if (com_lvl !== ec || seg_lvl !== es) begin
         n_fail++;
         $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h",
                  tag, com_lvl, seg_lvl, ec, es);
      end
   endtask

   task automatic model_restart();
      m_start = 1; m_slot = 0; m_pol = 0; m_cnt = 0;
   endtask

   task automatic model_tick();
      m_cnt++;
      if (m_cnt == TPS) begin
         m_cnt = 0;
         if (m_start) begin
            m_start = 0; m_slot = 0; m_pol = 0;
         end else if (m_slot == NC - 1) begin
            m_slot = 0; m_pol = !m_pol;
         end else begin
            m_slot++;
         end
         m_row = seg_img[m_slot*NS +: NS];
      end
   endtask

   task automatic one_tick();
      @(negedge clk); step_tick = 1'b1;
      @(posedge clk); model_tick();
      @(negedge clk); step_tick = 1'b0;
   endtask

   task automatic full_step();
      for (int k = 0; k < TPS; k++) one_tick();
   endtask

   task automatic do_resume();
      @(negedge clk); resume = 1'b1;
      @(posedge clk); model_restart();
      @(negedge clk); resume = 1'b0;
   endtask

   function automatic logic [NC*NS-1:0] make_img(input int p);
      logic [NC*NS-1:0] v;
      for (int i = 0; i < NC*NS; i++) begin
         case (p)
            0: v[i] = 1'b0;
            1: v[i] = 1'b1;
            2: v[i] = i[0];
            3: v[i] = ((i / NS) % 2) == 1;
            4: v[i] = (i % 3) == 0;
            default: v[i] = ((i * 7 + p) % 5) < 2;
         endcase
      end
      return v;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      model_restart();
      m_row = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R1: start-up mid level even with the display disabled
      check_pins("R1 reset state, display disabled");
      disp_en = 1'b1;
      #1 check_pins("R1 reset state, display enabled");
      // R4: partial step leaves start-up untouched
      seg_img = make_img(2);
      for (int k = 0; k < TPS - 1; k++) one_tick();
      check_pins("R4 partial step during start-up");
      one_tick();
      check_pins("R1 scan begins at slot 0 even polarity");

      // R4 R5 R6 R7: two full frames per image pattern
      for (int p = 0; p < 7; p++) begin
         do_resume();
         check_pins("R2 resume shows mid level");
         @(negedge clk); seg_img = make_img(p);
         full_step();
         for (int st = 0; st < 2*NC; st++) begin
            check_pins($sformatf("R5 R6 R7 pattern %0d step %0d", p, st));
            full_step();
         end
      end

      // R8: net DC over eight consecutive steps, measured at the outputs
      for (int p = 2; p < 5; p++) begin
         int acc [NC*NS];
         bit bad;
         @(negedge clk); seg_img = make_img(p);
         full_step();
         foreach (acc[i]) acc[i] = 0;
         for (int st = 0; st < 2*NC; st++) begin
            for (int c = 0; c < NC; c++)
               for (int s = 0; s < NS; s++)
                  acc[c*NS+s] += lv(com_lvl[2*c +: 2]) - lv(seg_lvl[2*s +: 2]);
            full_step();
         end
         bad = 0;
         n_chk++;
         foreach (acc[i]) if (acc[i] != 0 && !bad) begin
            bad = 1; n_fail++;
            $display("FAIL R8 pattern %0d pixel %0d: net=%0d expected 0", p, i, acc[i]);
         end
      end

      // R10: image change inside a slot does not show up early
      @(negedge clk); seg_img = make_img(1);
      full_step();
      @(negedge clk); seg_img = make_img(0);
      one_tick();
      check_pins("R10 mid-slot image change ignored");
      for (int k = 1; k < TPS - 1; k++) one_tick();
      @(negedge clk); seg_img = make_img(3);
      one_tick();
      check_pins("R10 image taken at slot start");

      // R9: disable while scanning; scanning continues
      @(negedge clk); disp_en = 1'b0;
      #1 check_pins("R9 disabled drives low");
      for (int st = 0; st < 5; st++) begin
         full_step();
         check_pins($sformatf("R9 disabled step %0d", st));
      end
      for (int k = 0; k < TPS - 1; k++) one_tick();
      @(negedge clk); disp_en = 1'b1;
      #1 check_pins("R9 re-enable resumes uninterrupted scan");
      one_tick();
      check_pins("R9 R7 step after re-enable");

      // R2: resume coinciding with a tick discards that tick
      @(negedge clk); resume = 1'b1; step_tick = 1'b1;
      @(posedge clk); model_restart();
      @(negedge clk); resume = 1'b0; step_tick = 1'b0;
      check_pins("R2 resume with simultaneous tick");
      for (int k = 0; k < TPS - 1; k++) one_tick();
      check_pins("R2 start-up lasts full step after resume");
      one_tick();
      check_pins("R2 scan restarts slot 0 even polarity");

      // R3: codes stay legal across a final sweep
      for (int st = 0; st < NC; st++) begin
         bit ill;
         full_step();
         ill = 0;
         for (int i = 0; i < NC; i++) if (com_lvl[2*i +: 2] == 2'b11) ill = 1;
         for (int i = 0; i < NS; i++) if (seg_lvl[2*i +: 2] == 2'b11) ill = 1;
         n_chk++;
         if (ill) begin
            n_fail++;
            $display("FAIL R3 step %0d: com=%h seg=%h expected no 2'b11 code", st, com_lvl, seg_lvl);
         end
      end

      finish_run();
   end

endmodule